// File: doc/BRIEF.md
# Line-Draw Blit Micro-Cycle Sequencer

This block steps a line-drawing blit through its micro-cycles, moving on by at most one cycle per colour clock. A start strobe captures a pixel count, the enables of the three source/target channel groups (A for the error term, B for the texture fetch, C for the read-modify-write of the destination word) and a single-dot flag. The sequencer then runs a lead-in, one short program per pixel, and a two-cycle tail. The channel enables select the length of the per-pixel program and decide which of its cycles claim the chip bus.

On every colour clock the sequencer reports the class of its pending cycle: internal, bus-free, or bus. A bus or bus-free cycle retires only in a colour clock that the arbiter marks free. An internal cycle retires in any colour clock. The sequencer gives a neighbouring datapath strobes to fetch the B word, fetch the C word, write the D word and advance the error accumulator. It keeps the B fetch address itself. It drives a busy level, a done pulse and a one-clock interrupt pulse.

Top module: `line_seq`

## Requirements
- R1: After reset, busy, irq, done, fetch_b, fetch_c, write_d and err_adv are all 0.
- R2: With B disabled, each pixel runs four cycles: a bus-free cycle, a C cycle, a bus-free propagate cycle and a D cycle. With C enabled, the C cycle is class bus (cyc_class 2'b10) and pulses fetch_c when it retires.
- R3: With B enabled, each pixel runs six cycles: bus-free, B fetch (class bus, fetch_b pulse), C cycle, bus-free, a bus-claiming cycle with no strobe (class bus), then the D cycle.
- R4: b_addr is loaded from b_base at start. Each B fetch uses the current b_addr. After each fetch, b_addr advances by b_mod sign-extended, wrapping at PTR_W bits, and by nothing else.
- R5: With C disabled, the C and D cycles are bus-free (cyc_class 2'b01). They never pulse fetch_c or write_d.
- R6: With C enabled, the D cycle is class bus even when the store is suppressed. write_d pulses when it retires unless single-dot mode is captured and dot_lock is high in that colour clock.
- R7: The lead-in is EXTRA_SLOTS internal cycles (2'b00), one bus-free start-delay cycle and one internal init cycle. After the last pixel come one internal cycle and a done cycle. The done cycle is internal with B disabled and bus-free with B enabled. The total is 2+EXTRA_SLOTS+pixels×(4 or 6)+2 retired cycles.
- R8: A bus or bus-free cycle in a colour clock with slot_free low does not retire. It keeps its class and pulses no strobe. Internal cycles retire whatever slot_free is.
- R9: irq is a one-clock pulse in the colour clock after the first colour clock spent in the done cycle, even if the done cycle stalls there.
- R10: busy is high from the clock after an accepted start until the done cycle retires, and done pulses in that retiring clock. A start while busy is ignored, and the enables and single-dot flag are captured at start.
- R11: A pixel count of zero runs exactly one pixel.
- R12: err_adv pulses when a D cycle retires if A was enabled at start, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour-clock rate clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start strobe, accepted when idle |
| pix_count | input | CNT_W | Pixels to draw (0 means 1) |
| use_a | input | 1 | Error-term channel enable |
| use_b | input | 1 | Texture fetch channel enable |
| use_c | input | 1 | Destination read/write channel enable |
| sing | input | 1 | Single-dot mode |
| dot_lock | input | 1 | From datapath: the row already has its dot |
| slot_free | input | 1 | Arbiter: this colour clock is free for the blitter |
| b_base | input | PTR_W | Texture pointer loaded at start |
| b_mod | input | MOD_W | Signed texture pointer modulo |
| busy | output | 1 | Blit in progress |
| cyc_class | output | 2 | Pending cycle: 00 internal, 01 bus-free, 10 bus |
| fetch_b | output | 1 | Texture word fetched this clock |
| b_addr | output | PTR_W | Texture fetch address |
| fetch_c | output | 1 | Destination word read this clock |
| write_d | output | 1 | Destination word stored this clock |
| err_adv | output | 1 | Error accumulator step this clock |
| done | output | 1 | Done cycle retires this clock |
| irq | output | 1 | Blit interrupt pulse |

## Verification
The assertions take for granted that dot_lock and slot_free are stable through a clock and that start arrives as a clean synchronous pulse. Enables changing while a blit runs are legal. The stimulus drives every input one time unit after the rising edge, holds slot_free either always high or low on a pseudo-random share of clocks, and toggles dot_lock the same way, so stalls hit every cycle class including the done cycle. It also pulses start with different flags in the middle of a blit, which keeps the stimulus inside these assumptions while exercising the ignore path.

// File: rtl/line_seq_pkg.sv
package line_seq_pkg;

   typedef enum logic [3:0] {
      PH_IDLE, PH_XTRA, PH_SDLY, PH_INIT,
      PH_L1, PH_LB, PH_L2, PH_L3, PH_LBUS, PH_L4,
      PH_TAIL, PH_DONE
   } phase_e;

   typedef enum logic [1:0] {
      CY_INT  = 2'b00,
      CY_FREE = 2'b01,
      CY_BUS  = 2'b10
   } cyc_e;

   typedef struct packed {
      logic use_a;
      logic use_b;
      logic use_c;
      logic sing;
   } chan_t;

endpackage

// File: rtl/line_seq_class.sv
module line_seq_class
   import line_seq_pkg::*;
(
   input  phase_e phase,
   input  logic   use_b,
   input  logic   use_c,
   output cyc_e   cls
);

   always_comb begin
      case (phase)
         PH_SDLY, PH_L1, PH_L3: cls = CY_FREE;
         PH_LB, PH_LBUS:        cls = CY_BUS;
         PH_L2, PH_L4:          cls = use_c ? CY_BUS : CY_FREE;
         PH_DONE:               cls = use_b ? CY_FREE : CY_INT;
         default:               cls = CY_INT;
      endcase
   end

endmodule

// File: rtl/line_seq_pixcnt.sv
module line_seq_pixcnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count_in,
   input  logic             dec,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= (count_in == '0) ? CNT_W'(1) : count_in;
      else if (dec)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign last = (cnt_q == CNT_W'(1));

   // R11: a pixel is never retired from an empty counter
   p_cnt_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0));

endmodule

// File: rtl/line_seq_bptr.sv
module line_seq_bptr #(
   parameter int PTR_W = 20,
   parameter int MOD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] base,
   input  logic [MOD_W-1:0] modulo,
   input  logic             step,
   output logic [PTR_W-1:0] addr
);

   localparam int PAD = PTR_W - MOD_W;

   logic [MOD_W-1:0] mod_q;
   logic [PTR_W-1:0] addr_q;
   logic [PTR_W-1:0] mod_ext;

   generate
      if (PAD > 0) begin : g_sext
         assign mod_ext = {{PAD{mod_q[MOD_W-1]}}, mod_q};
      end else begin : g_same
         assign mod_ext = mod_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mod_q  <= '0;
         addr_q <= '0;
      end else if (load) begin
         mod_q  <= modulo;
         addr_q <= base;
      end else if (step) begin
         addr_q <= addr_q + mod_ext;
      end
   end

   assign addr = addr_q;

   // R4: each texture fetch moves the pointer by exactly the modulo
   p_bstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (addr_q == $past(addr_q) + $past(mod_ext)));

endmodule

// File: rtl/line_seq_fsm.sv
module line_seq_fsm
   import line_seq_pkg::*;
#(
   parameter int EXTRA_SLOTS = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   input  chan_t  chan_in,
   input  logic   slot_free,
   input  logic   last_pix,
   input  cyc_e   cls,
   output phase_e phase,
   output chan_t  chan,
   output logic   adv,
   output logic   load
);

   localparam int     XW       = (EXTRA_SLOTS > 1) ? $clog2(EXTRA_SLOTS) : 1;
   localparam phase_e FIRST_PH = (EXTRA_SLOTS > 0) ? PH_XTRA : PH_SDLY;

   phase_e ph_q, ph_d;
   chan_t  chan_q;
   logic   xlast;

   assign adv  = (ph_q != PH_IDLE) && ((cls == CY_INT) || slot_free);
   assign load = (ph_q == PH_IDLE) && start;

   generate
      if (EXTRA_SLOTS > 0) begin : g_xtra
         logic [XW-1:0] xcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               xcnt_q <= '0;
            else if ((ph_q == PH_XTRA) && adv)
               xcnt_q <= xlast ? '0 : xcnt_q + XW'(1);
         end
         assign xlast = (xcnt_q == XW'(EXTRA_SLOTS - 1));
      end else begin : g_noxtra
         assign xlast = 1'b1;
      end
   endgenerate

   always_comb begin
      ph_d = ph_q;
      if (ph_q == PH_IDLE) begin
         if (start) ph_d = FIRST_PH;
      end else if (adv) begin
         case (ph_q)
            PH_XTRA: ph_d = xlast ? PH_SDLY : PH_XTRA;
            PH_SDLY: ph_d = PH_INIT;
            PH_INIT: ph_d = PH_L1;
            PH_L1:   ph_d = chan_q.use_b ? PH_LB : PH_L2;
            PH_LB:   ph_d = PH_L2;
            PH_L2:   ph_d = PH_L3;
            PH_L3:   ph_d = chan_q.use_b ? PH_LBUS : PH_L4;
            PH_LBUS: ph_d = PH_L4;
            PH_L4:   ph_d = last_pix ? PH_TAIL : PH_L1;
            PH_TAIL: ph_d = PH_DONE;
            PH_DONE: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         chan_q <= '0;
      end else begin
         ph_q <= ph_d;
         if (load) chan_q <= chan_in;
      end
   end

   assign phase = ph_q;
   assign chan  = chan_q;

   // R8: a denied cycle stays where it is
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q != PH_IDLE) && !adv) |=> (ph_q == $past(ph_q)));

   // R10: captured flags ignore a start that arrives while busy
   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q != PH_IDLE) && start) |=> $stable(chan_q));

   // R8: internal cycles never wait on the arbiter
   p_int_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q != PH_IDLE) && (cls == CY_INT)) |-> adv);

endmodule

// File: rtl/line_seq.sv
module line_seq
   import line_seq_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int PTR_W       = 20,
   parameter int MOD_W       = 16,
   parameter int EXTRA_SLOTS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] pix_count,
   input  logic             use_a,
   input  logic             use_b,
   input  logic             use_c,
   input  logic             sing,
   input  logic             dot_lock,
   input  logic             slot_free,
   input  logic [PTR_W-1:0] b_base,
   input  logic [MOD_W-1:0] b_mod,
   output logic             busy,
   output logic [1:0]       cyc_class,
   output logic             fetch_b,
   output logic [PTR_W-1:0] b_addr,
   output logic             fetch_c,
   output logic             write_d,
   output logic             err_adv,
   output logic             done,
   output logic             irq
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("line_seq: CNT_W must be at least 1");
      end
      if (PTR_W < 2) begin : g_bad_ptr
         $error("line_seq: PTR_W must be at least 2");
      end
      if ((MOD_W < 1) || (MOD_W > PTR_W)) begin : g_bad_mod
         $error("line_seq: MOD_W must lie in 1..PTR_W");
      end
      if (EXTRA_SLOTS < 0) begin : g_bad_xtra
         $error("line_seq: EXTRA_SLOTS must not be negative");
      end
   endgenerate

   phase_e phase;
   chan_t  chan, chan_in;
   cyc_e   cls;
   logic   adv, load, last_pix, pix_dec;
   logic   tried_q, irq_q;

   assign chan_in = '{use_a: use_a, use_b: use_b, use_c: use_c, sing: sing};

   line_seq_fsm #(.EXTRA_SLOTS(EXTRA_SLOTS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .chan_in   (chan_in),
      .slot_free (slot_free),
      .last_pix  (last_pix),
      .cls       (cls),
      .phase     (phase),
      .chan      (chan),
      .adv       (adv),
      .load      (load)
   );

   line_seq_class u_class (
      .phase (phase),
      .use_b (chan.use_b),
      .use_c (chan.use_c),
      .cls   (cls)
   );

   line_seq_pixcnt #(.CNT_W(CNT_W)) u_pixcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .count_in (pix_count),
      .dec      (pix_dec),
      .last     (last_pix)
   );

   line_seq_bptr #(.PTR_W(PTR_W), .MOD_W(MOD_W)) u_bptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .base   (b_base),
      .modulo (b_mod),
      .step   (fetch_b),
      .addr   (b_addr)
   );

   assign pix_dec   = adv && (phase == PH_L4);
   assign fetch_b   = adv && (phase == PH_LB);
   assign fetch_c   = adv && (phase == PH_L2) && chan.use_c;
   assign write_d   = pix_dec && chan.use_c && !(chan.sing && dot_lock);
   assign err_adv   = pix_dec && chan.use_a;
   assign done      = adv && (phase == PH_DONE);
   assign busy      = (phase != PH_IDLE);
   assign cyc_class = cls;
   assign irq       = irq_q;

   // interrupt: one clock after the first clock spent in the done cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tried_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q   <= (phase == PH_DONE) && !tried_q;
         tried_q <= (phase == PH_DONE) && !done;
      end
   end

   // R9: irq only follows a clock in the done cycle
   p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(phase) == PH_DONE));

   // R9: irq is a single-clock pulse
   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R10: the retiring done cycle ends busy
   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R8: at most one micro-cycle action per colour clock
   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_b, fetch_c, write_d, done}));

   // R6: a store only ever happens in a bus-class cycle
   p_dstore_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      write_d |-> (cls == CY_BUS));

   // R5: no destination traffic without the C channel
   p_no_c_traffic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !chan.use_c |-> !(fetch_c || write_d));

endmodule

// File: tb/test_line_seq.sv
`timescale 1ns/1ps
module test_line_seq;

   localparam int CW = 10;
   localparam int PW = 20;
   localparam int MW = 16;
   localparam int XS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] pix_count = '0;
   logic          use_a = 1'b0, use_b = 1'b0, use_c = 1'b0, sing = 1'b0;
   logic          dot_lock = 1'b0;
   logic          slot_free = 1'b1;
   logic [PW-1:0] b_base = '0;
   logic [MW-1:0] b_mod = '0;
   logic          busy, fetch_b, fetch_c, write_d, err_adv, done, irq;
   logic [1:0]    cyc_class;
   logic [PW-1:0] b_addr;

   always #2 clk = ~clk;

   line_seq #(.CNT_W(CW), .PTR_W(PW), .MOD_W(MW), .EXTRA_SLOTS(XS)) i_line_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .pix_count(pix_count),
      .use_a(use_a), .use_b(use_b), .use_c(use_c), .sing(sing),
      .dot_lock(dot_lock), .slot_free(slot_free), .b_base(b_base), .b_mod(b_mod),
      .busy(busy), .cyc_class(cyc_class), .fetch_b(fetch_b), .b_addr(b_addr),
      .fetch_c(fetch_c), .write_d(write_d), .err_adv(err_adv), .done(done), .irq(irq)
   );

   typedef struct {
      logic [1:0]    cls;
      bit            fb;
      bit            fc;
      bit            dcyc;
      bit            dn;
      bit            ea;
      logic [PW-1:0] addr;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   bad = 0;
   bit   stall_mode = 1'b0;
   bit   cur_sing = 1'b0;
   bit   exp_irq = 1'b0;
   bit   done_seen = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic push(input logic [1:0] c, input bit fb, input bit fc, input bit dcyc,
                       input bit dn, input bit ea, input logic [PW-1:0] ad, input string tg);
      exp_t e;
      e.cls = c; e.fb = fb; e.fc = fc; e.dcyc = dcyc; e.dn = dn; e.ea = ea;
      e.addr = ad; e.tag = tg;
      q.push_back(e);
   endtask

   // driver: starts a blit and queues the expected retired cycles
   task automatic run_blit(input int n, input bit a, input bit b, input bit c, input bit s,
                           input logic [PW-1:0] base, input logic [MW-1:0] md,
                           input bit poke_mid);
      logic [PW-1:0] ptr;
      int np;
      @(posedge clk); #1;
      start = 1'b1; pix_count = CW'(n);
      use_a = a; use_b = b; use_c = c; sing = s;
      b_base = base; b_mod = md; cur_sing = s;
      @(posedge clk); #1;
      start = 1'b0;
      // R7 lead-in
      for (int i = 0; i < XS; i++) push(2'b00, 0, 0, 0, 0, 0, '0, "R7");
      push(2'b01, 0, 0, 0, 0, 0, '0, "R7");
      push(2'b00, 0, 0, 0, 0, 0, '0, "R7");
      np  = (n == 0) ? 1 : n;   // R11
      ptr = base;
      for (int p = 0; p < np; p++) begin
         push(2'b01, 0, 0, 0, 0, 0, '0, "R2");
         if (b) begin
            push(2'b10, 1, 0, 0, 0, 0, ptr, "R3/R4");
            ptr = ptr + {{(PW-MW){md[MW-1]}}, md};
         end
         push(c ? 2'b10 : 2'b01, 0, c, 0, 0, 0, '0, c ? "R2" : "R5");
         push(2'b01, 0, 0, 0, 0, 0, '0, "R2");
         if (b) push(2'b10, 0, 0, 0, 0, 0, '0, "R3");
         push(c ? 2'b10 : 2'b01, 0, 0, c, 0, a, '0, c ? "R6/R12" : "R5/R12");
      end
      push(2'b00, 0, 0, 0, 0, 0, '0, "R7");
      push(b ? 2'b01 : 2'b00, 0, 0, 0, 1, 0, '0, "R7/R10");
      if (poke_mid) begin
         // R10: a start while busy with other settings must change nothing
         repeat (5) @(posedge clk);
         #1;
         start = 1'b1; pix_count = CW'(7);
         use_a = ~a; use_b = ~b; use_c = ~c; sing = ~s;
         b_base = ~base; b_mod = ~md;
         @(posedge clk); #1;
         start = 1'b0;
      end
      wait (q.size() == 0);
      repeat (3) @(posedge clk);
   endtask

   // arbiter and datapath model
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         slot_free = stall_mode ? (lfsr[0] | lfsr[4]) : 1'b1;
         dot_lock  = lfsr[5];
      end
   end

   // monitor: compares every colour clock against the queue head
   initial begin
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            chk(1'b0, "R10", "watchdog expired", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
         if (rst_n) begin
            chk(irq == exp_irq, "R9", "irq", irq, exp_irq);
            chk(busy == (q.size() != 0), "R10", "busy", busy, q.size() != 0);
            if (q.size() != 0) begin
               exp_t h;
               bit adv;
               h = q[0];
               exp_irq = h.dn && !done_seen;
               if (h.dn) done_seen = 1'b1;
               chk(cyc_class == h.cls, h.tag, "cycle class", cyc_class, h.cls);
               adv = (cyc_class == 2'b00) || slot_free;
               if (adv) begin
                  bit wexp;
                  wexp = h.dcyc && !(cur_sing && dot_lock);
                  chk(fetch_b == h.fb, h.tag, "fetch_b", fetch_b, h.fb);
                  if (h.fb) chk(b_addr == h.addr, "R4", "b_addr", b_addr, h.addr);
                  chk(fetch_c == h.fc, h.tag, "fetch_c", fetch_c, h.fc);
                  chk(write_d == wexp, h.tag, "write_d", write_d, wexp);
                  chk(err_adv == h.ea, "R12", "err_adv", err_adv, h.ea);
                  chk(done == h.dn, h.tag, "done", done, h.dn);
                  if (h.dn) done_seen = 1'b0;
                  void'(q.pop_front());
               end else begin
                  chk({fetch_b, fetch_c, write_d, err_adv, done} == 5'b0, "R8",
                      "strobe during stall", {fetch_b, fetch_c, write_d, err_adv, done}, 0);
               end
            end else begin
               exp_irq = 1'b0;
               chk({fetch_b, fetch_c, write_d, err_adv, done} == 5'b0, "R10",
                   "strobe while idle", {fetch_b, fetch_c, write_d, err_adv, done}, 0);
            end
         end
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
      chk({fetch_b, fetch_c, write_d, err_adv, done} == 5'b0, "R1", "strobes after reset",
          {fetch_b, fetch_c, write_d, err_adv, done}, 0);

      // R2: four-cycle pixels, C on, no stalls
      stall_mode = 1'b0;
      run_blit(3, 1, 0, 1, 0, 20'h00100, 16'h0028, 0);
      // R3/R4: six-cycle pixels with stalls, positive modulo
      stall_mode = 1'b1;
      run_blit(2, 1, 1, 1, 0, 20'h00200, 16'h0028, 0);
      // R4/R5: B on, C off, negative modulo wrapping below zero
      run_blit(3, 0, 1, 0, 0, 20'h00002, 16'hFFFE, 0);
      // R11/R12: zero pixels, A off, no B or C
      run_blit(0, 0, 0, 0, 0, 20'h0, 16'h0, 0);
      // R6: single-dot with live dot_lock under stalls
      run_blit(6, 1, 0, 1, 1, 20'h0, 16'h0, 0);
      // R6 with B on and single-dot
      run_blit(3, 0, 1, 1, 1, 20'hFFFFE, 16'h0004, 0);
      // R10: ignored start during a blit, R9 with done stalls
      run_blit(4, 1, 1, 1, 0, 20'h01000, 16'h8000, 1);
      run_blit(2, 0, 0, 1, 0, 20'h0, 16'h0, 1);
      // no stalls, B on: done cycle retires at once
      stall_mode = 1'b0;
      run_blit(1, 1, 1, 0, 0, 20'h00040, 16'h0002, 0);

      chk(q.size() == 0, "R10", "queue drained", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule